// File: doc/BRIEF.md
# Flash Program/Erase Sequencer

This block sits on the host side of a parallel NOR flash bus. It accepts one request at a time: a single-word program, a sector erase, a block erase or a whole-array erase. It then drives the multi-cycle unlock and command write sequence that the flash requires, timing each strobe in whole clock cycles. After the last write cycle it reads the target location over and over until the flash reports that its internal operation has finished.

Completion is judged by one of two methods, chosen per request by a configuration input. In data-polling mode, bit 7 of the read word must equal the expected value. That value is bit 7 of the programmed data for a program, and 1 for any erase. In toggle mode, bit 6 must equal bit 6 of the read just before it. A single read that looks finished is not trusted, because it may coincide with the end of the internal write. The engine therefore requires two further qualifying reads before it reports done. If the flash never finishes, a clock-count timeout ends the request with an error pulse.

Top module: `flash_wr_engine`

## Requirements
- R1: A program request (op code 0) produces exactly four write cycles: (0x5555, 0xAA), (0x2AAA, 0x55), (0x5555, 0xA0), then (request address, request data).
- R2: An erase request produces exactly six write cycles: (0x5555, 0xAA), (0x2AAA, 0x55), (0x5555, 0x80), (0x5555, 0xAA), (0x2AAA, 0x55), then a final cycle that depends on the op code. Op code 1 (sector) ends with (request address, 0x30), op code 2 (block) ends with (request address, 0x50), and op code 3 (whole array) ends with (0x5555, 0x10).
- R3: In every write cycle, the address is presented one clock before the write strobe falls. The chip select is low whenever the write strobe is low. Address and data stay unchanged and driven for as long as the strobe is low and at the clock where it rises. The strobe is low for exactly PULSE_CLKS clocks.
- R4: With cfg_toggle = 0, a status read qualifies when its bit 7 equals the expected bit: bit 7 of the request data for a program, or 1 for an erase.
- R5: With cfg_toggle = 1, a status read qualifies when its bit 6 equals bit 6 of the previous read of the same request. The first read of a request never qualifies.
- R6: done pulses only after three consecutive qualifying reads, meaning an apparent finish plus two confirming reads. A non-qualifying read restarts the count, and no further read is issued after the third.
- R7: If completion is not reached within TMO_CLKS clocks of polling, error pulses and the engine returns to idle.
- R8: busy is high from the clock after a request is accepted until the clock on which done or error pulses. A request presented while busy is ignored.
- R9: done and error are single-clock pulses and are never high together.
- R10: During a status read, the output-enable and chip select are low, the write strobe is high and the data bus is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, accepted when idle |
| req_op | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 whole-array erase |
| req_addr | input | AW | Target word address |
| req_data | input | DW | Word to program |
| cfg_toggle | input | 1 | Completion method: 0 data polling, 1 toggle |
| busy | output | 1 | Request in progress |
| done | output | 1 | Completion pulse |
| error | output | 1 | Timeout pulse |
| fl_addr | output | AW | Flash address bus |
| fl_dq_out | output | DW | Data driven to the flash |
| fl_dq_oe | output | 1 | Data bus drive enable |
| fl_dq_in | input | DW | Data read from the flash |
| fl_ce_n | output | 1 | Flash chip select, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write strobe, active low |

## Verification
The flash model in the bench can return one stale "finished" read inside the busy window. This catches an engine that skips the two confirming reads or that fails to restart its count: such an engine stops on the glitch, or one read early. Toggle mode is tested with zero busy reads and with both parities of the final bit 6. This exposes an engine that lets the first read qualify, or that compares against the wrong previous value. Program data with bit 7 clear and bit 7 set separates an engine that expects a fixed polarity. A flash that never finishes must produce an error rather than a hang. A request injected mid-sequence must leave the written sequence untouched.

// File: rtl/flw_pkg.sv
package flw_pkg;
    typedef enum logic [1:0] {OP_PROG = 2'd0, OP_SECT = 2'd1, OP_BLK = 2'd2, OP_CHIP = 2'd3} flw_op_e;
    typedef enum logic [1:0] {S_IDLE = 2'd0, S_WRITE = 2'd1, S_POLL = 2'd2} flw_st_e;
endpackage

// File: rtl/flw_cmd_table.sv
module flw_cmd_table
    import flw_pkg::*;
#(
    parameter int AW = 18,
    parameter int DW = 16
) (
    input  flw_op_e         op,
    input  logic [2:0]      step,
    input  logic [AW-1:0]   tgt_addr,
    input  logic [DW-1:0]   tgt_data,
    output logic [AW-1:0]   cyc_addr,
    output logic [DW-1:0]   cyc_data,
    output logic            cyc_last
);
    localparam logic [AW-1:0] UNLK_A = AW'(32'h5555);
    localparam logic [AW-1:0] UNLK_B = AW'(32'h2AAA);

    always_comb begin
        cyc_addr = UNLK_A;
        cyc_data = DW'(8'hAA);
        cyc_last = 1'b0;
        if (op == OP_PROG) begin
            case (step)
                3'd0: begin cyc_addr = UNLK_A; cyc_data = DW'(8'hAA); end
                3'd1: begin cyc_addr = UNLK_B; cyc_data = DW'(8'h55); end
                3'd2: begin cyc_addr = UNLK_A; cyc_data = DW'(8'hA0); end
                default: begin cyc_addr = tgt_addr; cyc_data = tgt_data; cyc_last = 1'b1; end
            endcase
        end else begin
            case (step)
                3'd0: begin cyc_addr = UNLK_A; cyc_data = DW'(8'hAA); end
                3'd1: begin cyc_addr = UNLK_B; cyc_data = DW'(8'h55); end
                3'd2: begin cyc_addr = UNLK_A; cyc_data = DW'(8'h80); end
                3'd3: begin cyc_addr = UNLK_A; cyc_data = DW'(8'hAA); end
                3'd4: begin cyc_addr = UNLK_B; cyc_data = DW'(8'h55); end
                default: begin
                    cyc_last = 1'b1;
                    case (op)
                        OP_SECT: begin cyc_addr = tgt_addr; cyc_data = DW'(8'h30); end
                        OP_BLK:  begin cyc_addr = tgt_addr; cyc_data = DW'(8'h50); end
                        default: begin cyc_addr = UNLK_A;   cyc_data = DW'(8'h10); end
                    endcase
                end
            endcase
        end
    end
endmodule

// File: rtl/flw_poll_judge.sv
module flw_poll_judge #(
    parameter int DW = 16
) (
    input  logic          toggle_mode,
    input  logic [DW-1:0] rd_word,
    input  logic          exp_bit7,
    input  logic          have_prev,
    input  logic          prev_bit6,
    output logic          qualifies
);
    always_comb begin
        if (toggle_mode) qualifies = have_prev && (rd_word[6] == prev_bit6);
        else             qualifies = (rd_word[7] == exp_bit7);
    end
endmodule

// File: rtl/flash_wr_engine.sv
module flash_wr_engine
    import flw_pkg::*;
#(
    parameter int AW         = 18,
    parameter int DW         = 16,
    parameter int CYC_CLKS   = 4,
    parameter int PULSE_CLKS = 2,
    parameter int TMO_CLKS   = 5000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    input  logic          cfg_toggle,
    output logic          busy,
    output logic          done,
    output logic          error,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_dq_out,
    output logic          fl_dq_oe,
    input  logic [DW-1:0] fl_dq_in,
    output logic          fl_ce_n,
    output logic          fl_oe_n,
    output logic          fl_we_n
);
    localparam int PHW = (CYC_CLKS > 2) ? $clog2(CYC_CLKS) : 1;
    localparam int TMW = $clog2(TMO_CLKS + 1);
    localparam logic [PHW-1:0] PH_LAST  = PHW'(CYC_CLKS - 1);
    localparam logic [PHW-1:0] PH_PULSE = PHW'(PULSE_CLKS);
    localparam logic [TMW-1:0] TMO_LAST = TMW'(TMO_CLKS - 1);

    typedef struct packed {
        flw_st_e        st;
        flw_op_e        op;
        logic [AW-1:0]  addr;
        logic [DW-1:0]  data;
        logic [2:0]     step;
        logic [PHW-1:0] ph;
        logic [1:0]     cnf;
        logic           prev6;
        logic           have;
        logic           tgl;
        logic [TMW-1:0] tmo;
        logic           done;
        logic           err;
    } ctl_t;

    ctl_t q, d;
    logic [AW-1:0] cyc_addr;
    logic [DW-1:0] cyc_data;
    logic          cyc_last;
    logic          qualifies;
    logic          exp7;
    logic          in_pulse;

    assign exp7 = (q.op == OP_PROG) ? q.data[7] : 1'b1;

    flw_cmd_table #(.AW(AW), .DW(DW)) u_tbl (
        .op(q.op), .step(q.step), .tgt_addr(q.addr), .tgt_data(q.data),
        .cyc_addr(cyc_addr), .cyc_data(cyc_data), .cyc_last(cyc_last)
    );

    flw_poll_judge #(.DW(DW)) u_judge (
        .toggle_mode(q.tgl), .rd_word(fl_dq_in), .exp_bit7(exp7),
        .have_prev(q.have), .prev_bit6(q.prev6), .qualifies(qualifies)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.err  = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (req_valid) begin
                    d.st   = S_WRITE;
                    d.op   = flw_op_e'(req_op);
                    d.addr = req_addr;
                    d.data = req_data;
                    d.tgl  = cfg_toggle;
                    d.step = '0;
                    d.ph   = '0;
                    d.cnf  = '0;
                    d.have = 1'b0;
                    d.tmo  = '0;
                end
            end
            S_WRITE: begin
                if (q.ph == PH_LAST) begin
                    d.ph = '0;
                    if (cyc_last) d.st = S_POLL;
                    else          d.step = q.step + 3'd1;
                end else begin
                    d.ph = q.ph + 1'b1;
                end
            end
            S_POLL: begin
                d.tmo = q.tmo + 1'b1;
                if (q.tmo == TMO_LAST) begin
                    d.st  = S_IDLE;
                    d.err = 1'b1;
                end else if (q.ph == PH_LAST) begin
                    d.ph    = '0;
                    d.prev6 = fl_dq_in[6];
                    d.have  = 1'b1;
                    if (qualifies) begin
                        if (q.cnf == 2'd2) begin
                            d.st   = S_IDLE;
                            d.done = 1'b1;
                        end else begin
                            d.cnf = q.cnf + 2'd1;
                        end
                    end else begin
                        d.cnf = '0;
                    end
                end else begin
                    d.ph = q.ph + 1'b1;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign in_pulse  = (q.ph != '0) && (q.ph <= PH_PULSE);
    assign busy      = (q.st != S_IDLE);
    assign done      = q.done;
    assign error     = q.err;
    assign fl_addr   = (q.st == S_WRITE) ? cyc_addr : q.addr;
    assign fl_dq_out = cyc_data;
    assign fl_dq_oe  = (q.st == S_WRITE);
    assign fl_we_n   = !((q.st == S_WRITE) && in_pulse);
    assign fl_oe_n   = !((q.st == S_POLL) && (q.ph != '0));
    assign fl_ce_n   = fl_we_n && fl_oe_n;

    p_pulse_ends_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done || error) |-> (!busy && $past(busy)));
    p_pulse_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));
    p_strobe_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> ($stable(fl_addr) && $stable(fl_dq_out) && !fl_ce_n && fl_dq_oe));
    p_read_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_oe_n |-> (fl_we_n && !fl_dq_oe && !fl_ce_n));
    p_busy_ignores_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(q.addr) && $stable(q.op) && $stable(q.data)));
endmodule

// File: tb/sim_flash_wr_engine.sv
module sim_flash_wr_engine;
    localparam int AW = 18, DW = 16, CYC = 4, PULSE = 2, TMO = 600;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, cfg_toggle = 1'b0;
    logic [1:0] req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic busy, done, error, fl_dq_oe, fl_ce_n, fl_oe_n, fl_we_n;
    logic [AW-1:0] fl_addr;
    logic [DW-1:0] fl_dq_out;
    logic [DW-1:0] fl_dq_in = '0;

    flash_wr_engine #(.AW(AW), .DW(DW), .CYC_CLKS(CYC), .PULSE_CLKS(PULSE), .TMO_CLKS(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
        .req_data(req_data), .cfg_toggle(cfg_toggle), .busy(busy), .done(done), .error(error),
        .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in),
        .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
    );

    always #2 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // bench-side state of the current request
    logic [AW-1:0] wa [8];
    logic [DW-1:0] wd [8];
    int nw, n_need, wlow, proto_bad, nreads, busy_n, glitch_n, consec, ndone, nerr;
    bit armed, have6, prev6, last6, exp7, mode;
    logic [DW-1:0] fv;
    logic we_prev = 1'b1, oe_prev = 1'b1;
    logic [AW-1:0] addr_prev = '0;

    function automatic logic [AW+DW-1:0] exp_cyc(input int op, input int i, input logic [AW-1:0] a,
                                                  input logic [DW-1:0] dt);
        logic [AW-1:0] ea; logic [DW-1:0] ed;
        if (i == 1 || i == 4) ea = AW'(32'h2AAA); else ea = AW'(32'h5555);
        case (i)
            0, 3: ed = 16'h00AA;
            1, 4: ed = 16'h0055;
            2:    ed = (op == 0) ? 16'h00A0 : 16'h0080;
            default: ed = 16'h0000;
        endcase
        if (op == 0 && i == 3) begin ea = a; ed = dt; end
        if (i == 5) begin
            ed = (op == 1) ? 16'h0030 : (op == 2) ? 16'h0050 : 16'h0010;
            ea = (op == 3) ? AW'(32'h5555) : a;
        end
        return {ea, ed};
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (!fl_we_n && we_prev) begin
                if (fl_addr != addr_prev || fl_ce_n || !fl_dq_oe) proto_bad++;
                wlow = 1;
            end else if (!fl_we_n) begin
                wlow++;
            end
            if (fl_we_n && !we_prev) begin
                if (wlow != PULSE || !fl_dq_oe) proto_bad++;
                if (nw < 8) begin wa[nw] = fl_addr; wd[nw] = fl_dq_out; end
                nw++;
                if (nw == n_need) armed = 1'b1;
            end
            if (!fl_oe_n && oe_prev) begin
                logic [DW-1:0] v;
                bit ok;
                if (!armed || !fl_we_n || fl_dq_oe || fl_ce_n) proto_bad++;
                nreads++;
                v = fv;
                if (nreads <= busy_n && nreads != glitch_n) begin
                    v[7] = ~exp7; v[6] = ~last6;
                end else if (nreads == glitch_n) begin
                    v[7] = exp7; v[6] = last6;
                end
                last6 = v[6];
                fl_dq_in = v;
                ok = mode ? (have6 && v[6] == prev6) : (v[7] == exp7);
                consec = ok ? consec + 1 : 0;
                prev6 = v[6];
                have6 = 1'b1;
            end
            if (done) ndone++;
            if (error) nerr++;
            if (done && error) proto_bad++;
        end
        we_prev = fl_we_n;
        oe_prev = fl_oe_n;
        addr_prev = fl_addr;
    end

    task automatic run_op(input int op, input logic [AW-1:0] a, input logic [DW-1:0] dt,
                          input bit tg, input int bsy, input int gl, input bit inject);
        int cyc;
        bit want_err;
        want_err = (bsy > 100000);
        nw = 0; n_need = (op == 0) ? 4 : 6; proto_bad = 0; nreads = 0; consec = 0;
        ndone = 0; nerr = 0; armed = 1'b0; have6 = 1'b0; mode = tg;
        busy_n = bsy; glitch_n = gl; last6 = $urandom % 2;
        exp7 = (op == 0) ? dt[7] : 1'b1;
        fv = (op == 0) ? dt : 16'hFFFF;
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'(op); req_addr = a; req_data = dt; cfg_toggle = tg;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R8 busy after accept", busy, 1);
        cyc = 1;
        while (ndone + nerr == 0 && cyc < 3000) begin
            if (inject && cyc == 3) begin
                req_valid = 1'b1; req_op = 2'(3 - op); req_addr = ~a; req_data = ~dt;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        req_valid = 1'b0;
        check(busy == 1'b0, "R8 busy low at pulse", busy, 0);
        repeat (3) @(negedge clk);
        check(ndone + nerr == 1 && proto_bad == 0, "R9 single pulse / R3 R10 bus protocol",
              {ndone, nerr, proto_bad}, 1);
        check(nw == n_need, op == 0 ? "R1 write count" : "R2 write count", nw, n_need);
        for (int i = 0; i < n_need && i < nw; i++) begin
            logic [AW+DW-1:0] e;
            e = exp_cyc(op, i, a, dt);
            check({wa[i], wd[i]} == e, op == 0 ? "R1 write cycle" : "R2 write cycle", {wa[i], wd[i]}, e);
        end
        if (want_err) begin
            check(nerr == 1 && ndone == 0, "R7 timeout error", nerr, 1);
            check(cyc >= TMO && cyc <= TMO + 6 * CYC + 4, "R7 timeout latency", cyc, TMO);
        end else begin
            check(ndone == 1 && consec == 3, tg ? "R5 R6 toggle completion" : "R4 R6 poll completion",
                  consec, 3);
        end
        check(fl_oe_n && fl_we_n && fl_ce_n && !busy, "R8 idle bus after request",
              {fl_oe_n, fl_we_n, fl_ce_n, busy}, 4'b1110);
    endtask

    initial begin
        void'($urandom(32'd7));
        repeat (3) @(negedge clk);
        check(!busy && !done && !error && fl_we_n && fl_oe_n && fl_ce_n && !fl_dq_oe,
              "R8 R9 reset state", {busy, done, error}, 0);
        rst_n = 1'b1;
        // directed corners
        run_op(0, 18'h12345, 16'h1234, 1'b0, 5, 0, 1'b0);   // R4 bit7 clear
        run_op(0, 18'h00042, 16'hBEEF, 1'b0, 6, 3, 1'b0);   // R6 glitch, R4 bit7 set
        run_op(1, 18'h3F800, 16'h0000, 1'b1, 0, 0, 1'b0);   // R5 no busy reads
        run_op(0, 18'h00100, 16'h0040, 1'b1, 3, 0, 1'b0);   // R5 parity case
        run_op(0, 18'h00100, 16'h0000, 1'b1, 3, 0, 1'b0);   // R5 parity case
        run_op(2, 18'h28000, 16'h0000, 1'b1, 7, 4, 1'b1);   // R8 ignored request, R6 glitch
        run_op(3, 18'h00000, 16'h0000, 1'b0, 4, 2, 1'b0);   // R2 whole array
        run_op(0, 18'h00777, 16'h5A5A, 1'b0, 1000000, 0, 1'b0); // R7 never finishes
        // constrained random
        for (int k = 0; k < 16; k++) begin
            int op, b, g;
            op = $urandom % 4;
            b = $urandom % 12;
            g = (b >= 2 && ($urandom % 2) == 1) ? 1 + ($urandom % (b - 1)) : 0;
            run_op(op, AW'($urandom), DW'($urandom), 1'($urandom), b, g, 1'($urandom));
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule